// File: doc/BRIEF.md
# Shifter and Rotated-Immediate Operand Unit

This block produces the second operand of a 32-bit data-processing datapath, together with the carry that the shifter passes to the flag logic. In the register form it takes a source value and shifts or rotates it by a count. The count comes from a 5-bit immediate field or from the low byte of an amount register. In the immediate form it takes an 8-bit constant and rotates it right by twice a 4-bit field. Six shift-kind codes are decoded. Two of them are the same left shift, and one is a single-bit rotate through the incoming carry.

The operand and carry are computed combinationally and captured in one output register stage. Every set of inputs therefore shows up on the outputs one clock edge later. The surrounding pipeline supplies the source value, the carry flag and the decoded fields. The ALU consumes `op_out` and `carry_out`.

Top module: `opnd_shifter_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `op_out` and `carry_out` become 0. Otherwise both outputs show, after each rising edge, the result for the inputs sampled at that edge.
- R2: With `sel_imm`=1 the result is the rotated immediate. `src_val`, `shift_kind` and both count fields have no effect.
- R3: In the immediate form (`sel_imm`=1) the result is `imm_byte`, zero-extended to 32 bits and rotated right by 2×`imm_rot`. `carry_out` is bit 31 of that result when `imm_rot`≠0 and is `carry_in` when `imm_rot`=0.
- R4: The shift count is `imm_amt` (0..31) when `amt_from_reg`=0 and `reg_cnt` (0..255) when `amt_from_reg`=1.
- R5: A count of 0 with `shift_kind` 0, 1, 2, 3 or 5 returns `src_val` unchanged, with `carry_out`=`carry_in`.
- R6: `shift_kind`=0 (logical left) and `shift_kind`=5 (arithmetic left) behave identically. For a count n in 1..31 the result is `src_val` shifted left by n with zeros in, and `carry_out` = `src_val[32-n]`.
- R7: `shift_kind`=1 (logical right) with n in 1..31 shifts right with zeros in, and `carry_out` = `src_val[n-1]`.
- R8: `shift_kind`=2 (arithmetic right) with n in 1..31 shifts right and copies bit 31 into the vacated bits, and `carry_out` = `src_val[n-1]`.
- R9: A logical shift (kind 0, 5 or 1) by exactly 32 returns 0, with `carry_out` = `src_val[0]` for left shifts and `src_val[31]` for right shifts. A logical shift by more than 32 returns 0 with `carry_out`=0.
- R10: An arithmetic right shift by 32 or more sets every result bit and `carry_out` to `src_val[31]`.
- R11: `shift_kind`=3 (rotate right) rotates by the count modulo 32. For a nonzero remainder m, `carry_out` = `src_val[m-1]`. A nonzero count that is a multiple of 32 returns `src_val` with `carry_out` = `src_val[31]`.
- R12: `shift_kind`=4 (extended rotate) returns {`carry_in`, `src_val[31:1]`} with `carry_out` = `src_val[0]`, whatever the count.
- R13: The unused codes `shift_kind`=6 and 7 return `src_val` unchanged with `carry_out`=`carry_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_imm | input | 1 | 1 selects the rotated immediate, 0 the shifted register |
| imm_byte | input | 8 | Immediate constant |
| imm_rot | input | 4 | Immediate rotate field (rotation = 2 × field) |
| src_val | input | 32 | Register value to shift |
| shift_kind | input | 3 | Shift kind code (see R6–R13) |
| amt_from_reg | input | 1 | 1 takes the count from `reg_cnt`, 0 from `imm_amt` |
| imm_amt | input | 5 | Immediate shift count |
| reg_cnt | input | 8 | Low byte of the amount register |
| carry_in | input | 1 | Current carry flag |
| op_out | output | 32 | Registered operand |
| carry_out | output | 1 | Registered shifter carry |

## Verification
Count-source selection and the count-range handling both act on every register-form operation in a single cycle. A byte count of 0, 32, 33, 64 or 255 decides the result only when `amt_from_reg` routes it through, and the immediate field stays below 32. The bench provokes this with directed pairs that hold conflicting values in the two count fields, and with random cases biased toward those boundary counts. A bit-serial reference model judges each result, so a wrong source or a wrong saturation rule shows up as a mismatch in data or carry. Immediate selection against live shift fields, and the extended rotate against nonzero counts, are judged the same way.

// File: rtl/opnd_pkg.sv
package opnd_pkg;
  typedef enum logic [2:0] {
    SK_LSL = 3'd0,
    SK_LSR = 3'd1,
    SK_ASR = 3'd2,
    SK_ROR = 3'd3,
    SK_RRX = 3'd4,
    SK_ASL = 3'd5
  } shift_kind_e;
endpackage

// File: rtl/opnd_rotr.sv
module opnd_rotr #(
  parameter int W  = 32,
  parameter int SH = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SH-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stg [SH+1];

  assign stg[0] = din;

  // one stage per bit of the amount: stage i rotates by 2**i
  for (genvar i = 0; i < SH; i++) begin : g_stage
    localparam int STEP = 1 << i;
    assign stg[i+1] = amt[i] ? {stg[i][STEP-1:0], stg[i][W-1:STEP]} : stg[i];
  end

  assign dout = stg[SH];
endmodule

// File: rtl/opnd_count_sel.sv
module opnd_count_sel #(
  parameter int IAW = 5,
  parameter int CW  = 8
) (
  input  logic           from_reg,
  input  logic [IAW-1:0] imm_amt,
  input  logic [CW-1:0]  reg_cnt,
  output logic [CW-1:0]  cnt
);
  assign cnt = from_reg ? reg_cnt : CW'(imm_amt);
endmodule

// File: rtl/opnd_imm_rot.sv
module opnd_imm_rot #(
  parameter int W  = 32,
  parameter int IW = 8,
  parameter int RW = 4
) (
  input  logic [IW-1:0] imm_byte,
  input  logic [RW-1:0] imm_rot,
  input  logic          cin,
  output logic [W-1:0]  res,
  output logic          cout
);
  localparam int SH = $clog2(W);

  logic [SH-1:0] amt;
  assign amt = SH'({imm_rot, 1'b0});

  opnd_rotr #(.W(W), .SH(SH)) u_rot (
    .din  (W'(imm_byte)),
    .amt  (amt),
    .dout (res)
  );

  assign cout = (imm_rot != '0) ? res[W-1] : cin;
endmodule

// File: rtl/opnd_shift_core.sv
module opnd_shift_core
  import opnd_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = 8
) (
  input  logic [W-1:0]  src,
  input  logic [2:0]    kind,
  input  logic [CW-1:0] cnt,
  input  logic          cin,
  output logic [W-1:0]  res,
  output logic          cout
);
  localparam int SH = $clog2(W);
  localparam logic [CW-1:0] W_C = CW'(W);

  shift_kind_e   k;
  logic [SH-1:0] nlow, idx_left, idx_right, rot_amt;
  logic [W-1:0]  rotated, lo_mask, hi_mask;
  logic          is_zero, below_w, at_w, sgn;

  assign k         = shift_kind_e'(kind);
  assign nlow      = cnt[SH-1:0];
  assign idx_left  = SH'(0) - nlow;       // W - n modulo W
  assign idx_right = nlow - SH'(1);       // n - 1 modulo W
  assign is_zero   = (cnt == '0);
  assign below_w   = (cnt < W_C);
  assign at_w      = (cnt == W_C);
  assign sgn       = src[W-1];
  assign lo_mask   = {W{1'b1}} >> nlow;
  assign hi_mask   = {W{1'b1}} << nlow;
  assign rot_amt   = (k == SK_LSL || k == SK_ASL) ? idx_left : nlow;

  // left shifts reuse the right rotator with the complementary amount
  opnd_rotr #(.W(W), .SH(SH)) u_rot (
    .din  (src),
    .amt  (rot_amt),
    .dout (rotated)
  );

  always_comb begin
    res  = src;
    cout = cin;
    unique case (k)
      SK_LSL, SK_ASL: begin
        if (!is_zero) begin
          if (below_w) begin
            res  = rotated & hi_mask;
            cout = src[idx_left];
          end else begin
            res  = '0;
            cout = at_w ? src[0] : 1'b0;
          end
        end
      end
      SK_LSR: begin
        if (!is_zero) begin
          if (below_w) begin
            res  = rotated & lo_mask;
            cout = src[idx_right];
          end else begin
            res  = '0;
            cout = at_w ? src[W-1] : 1'b0;
          end
        end
      end
      SK_ASR: begin
        if (!is_zero) begin
          if (below_w) begin
            res  = (rotated & lo_mask) | (sgn ? ~lo_mask : '0);
            cout = src[idx_right];
          end else begin
            res  = {W{sgn}};
            cout = sgn;
          end
        end
      end
      SK_ROR: begin
        if (!is_zero) begin
          res  = rotated;
          cout = src[idx_right];
        end
      end
      SK_RRX: begin
        res  = {cin, src[W-1:1]};
        cout = src[0];
      end
      default: begin
        res  = src;
        cout = cin;
      end
    endcase
  end
endmodule

// File: rtl/opnd_shifter_unit.sv
module opnd_shifter_unit
  import opnd_pkg::*;
#(
  parameter int W   = 32,
  parameter int IW  = 8,
  parameter int RW  = 4,
  parameter int IAW = 5,
  parameter int CW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sel_imm,
  input  logic [IW-1:0]  imm_byte,
  input  logic [RW-1:0]  imm_rot,
  input  logic [W-1:0]   src_val,
  input  logic [2:0]     shift_kind,
  input  logic           amt_from_reg,
  input  logic [IAW-1:0] imm_amt,
  input  logic [CW-1:0]  reg_cnt,
  input  logic           carry_in,
  output logic [W-1:0]   op_out,
  output logic           carry_out
);
  logic [CW-1:0] cnt;
  logic [W-1:0]  sh_res, im_res;
  logic          sh_c, im_c;

  opnd_count_sel #(.IAW(IAW), .CW(CW)) u_cnt (
    .from_reg (amt_from_reg),
    .imm_amt  (imm_amt),
    .reg_cnt  (reg_cnt),
    .cnt      (cnt)
  );

  opnd_shift_core #(.W(W), .CW(CW)) u_shift (
    .src  (src_val),
    .kind (shift_kind),
    .cnt  (cnt),
    .cin  (carry_in),
    .res  (sh_res),
    .cout (sh_c)
  );

  opnd_imm_rot #(.W(W), .IW(IW), .RW(RW)) u_imm (
    .imm_byte (imm_byte),
    .imm_rot  (imm_rot),
    .cin      (carry_in),
    .res      (im_res),
    .cout     (im_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_out    <= '0;
      carry_out <= 1'b0;
    end else begin
      op_out    <= sel_imm ? im_res : sh_res;
      carry_out <= sel_imm ? im_c : sh_c;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (op_out == '0 && !carry_out)); // R1
  AST_IMM_NO_ROT: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $past(sel_imm) && $past(imm_rot) == '0) |-> (op_out == W'($past(imm_byte)) && carry_out == $past(carry_in))); // R3
  AST_ZERO_COUNT_PASS: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && !$past(sel_imm) && $past(shift_kind) != 3'd4 && $past(cnt) == '0) |-> (op_out == $past(src_val) && carry_out == $past(carry_in))); // R5
  AST_LOGIC_BEYOND: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && !$past(sel_imm) && ($past(shift_kind) == 3'd0 || $past(shift_kind) == 3'd1 || $past(shift_kind) == 3'd5) && $past(cnt) > CW'(W)) |-> (op_out == '0 && !carry_out)); // R9
  AST_ASR_SATURATE: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && !$past(sel_imm) && $past(shift_kind) == 3'd2 && $past(cnt) >= CW'(W)) |-> (op_out == {W{$past(src_val[W-1])}} && carry_out == $past(src_val[W-1]))); // R10
  AST_RRX_EXTEND: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && !$past(sel_imm) && $past(shift_kind) == 3'd4) |-> (op_out == {$past(carry_in), $past(src_val[W-1:1])} && carry_out == $past(src_val[0]))); // R12
  AST_SPARE_CODES: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && !$past(sel_imm) && $past(shift_kind) >= 3'd6) |-> (op_out == $past(src_val) && carry_out == $past(carry_in))); // R13
endmodule

// File: tb/opnd_shifter_unit_test.sv
`timescale 1ns/1ps
module opnd_shifter_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_imm = 1'b0;
  logic [7:0]  imm_byte = '0;
  logic [3:0]  imm_rot = '0;
  logic [31:0] src_val = '0;
  logic [2:0]  shift_kind = '0;
  logic        amt_from_reg = 1'b0;
  logic [4:0]  imm_amt = '0;
  logic [7:0]  reg_cnt = '0;
  logic        carry_in = 1'b0;
  logic [31:0] op_out;
  logic        carry_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  opnd_shifter_unit uut (
    .clk(clk), .rst(rst), .sel_imm(sel_imm), .imm_byte(imm_byte), .imm_rot(imm_rot),
    .src_val(src_val), .shift_kind(shift_kind), .amt_from_reg(amt_from_reg),
    .imm_amt(imm_amt), .reg_cnt(reg_cnt), .carry_in(carry_in),
    .op_out(op_out), .carry_out(carry_out)
  );

  // bit-serial reference: returns {carry, value}
  function automatic logic [32:0] ref_model(logic s, logic [7:0] b, logic [3:0] r, logic [31:0] v,
                                            logic [2:0] k, logic fr, logic [4:0] ia,
                                            logic [7:0] rc, logic ci);
    logic [31:0] x;
    logic c;
    int n;
    if (s) begin
      x = {24'd0, b};
      for (int i = 0; i < 2 * int'(r); i++) x = {x[0], x[31:1]};
      c = (r != 0) ? x[31] : ci;
      return {c, x};
    end
    n = fr ? int'(rc) : int'(ia);
    x = v;
    c = ci;
    if (k == 3'd4) return {v[0], ci, v[31:1]};
    if (k >= 3'd6 || n == 0) return {ci, v};
    case (k)
      3'd0, 3'd5: for (int i = 0; i < n; i++) begin c = x[31]; x = x << 1; end
      3'd1: for (int i = 0; i < n; i++) begin c = x[0]; x = x >> 1; end
      3'd2: for (int i = 0; i < n; i++) begin c = x[0]; x = {x[31], x[31:1]}; end
      default: begin
        if (n % 32 == 0) c = x[31];
        else for (int i = 0; i < n % 32; i++) begin c = x[0]; x = {x[0], x[31:1]}; end
      end
    endcase
    return {c, x};
  endfunction

  function automatic string tag_of(logic s, logic [2:0] k, int n);
    if (s) return "R2/R3";
    case (k)
      3'd4: return "R12";
      3'd6, 3'd7: return "R13";
      default: ;
    endcase
    if (n == 0) return "R5";
    case (k)
      3'd0, 3'd5: return (n < 32) ? "R6" : "R9";
      3'd1: return (n < 32) ? "R7" : "R9";
      3'd2: return (n < 32) ? "R8" : "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] got_v, logic got_c, logic [31:0] exp_v, logic exp_c);
    checks++;
    if (got_v !== exp_v || got_c !== exp_c) begin
      errors++;
      $display("FAIL %s: got op=%08h c=%0b, expected op=%08h c=%0b", tag, got_v, got_c, exp_v, exp_c);
    end
  endtask

  task automatic run(string tag, logic s, logic [7:0] b, logic [3:0] r, logic [31:0] v,
                     logic [2:0] k, logic fr, logic [4:0] ia, logic [7:0] rc, logic ci);
    logic [32:0] e;
    sel_imm = s; imm_byte = b; imm_rot = r; src_val = v; shift_kind = k;
    amt_from_reg = fr; imm_amt = ia; reg_cnt = rc; carry_in = ci;
    e = ref_model(s, b, r, v, k, fr, ia, rc, ci);
    @(posedge clk);
    @(negedge clk);
    check(tag, op_out, carry_out, e[31:0], e[32]);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset clears outputs even with live inputs
    src_val = 32'hFFFF_FFFF; carry_in = 1'b1; shift_kind = 3'd4;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", op_out, carry_out, 32'h0, 1'b0);
    rst = 1'b0;

    // R3 immediate form
    run("R3", 1, 8'hFF, 4'd0, 32'h0, 3'd0, 0, 5'd0, 8'd0, 1'b1);
    run("R3", 1, 8'h81, 4'd1, 32'h0, 3'd0, 0, 5'd0, 8'd0, 1'b0);
    run("R3", 1, 8'h3C, 4'd15, 32'h0, 3'd0, 0, 5'd0, 8'd0, 1'b1);
    run("R3", 1, 8'h01, 4'd4, 32'h0, 3'd0, 0, 5'd0, 8'd0, 1'b1);
    // R2: shift fields have no effect on the immediate path
    run("R2", 1, 8'h5A, 4'd3, 32'hDEAD_BEEF, 3'd2, 1, 5'd17, 8'd200, 1'b0);
    // R4: conflicting count fields
    run("R4", 0, 8'h0, 4'd0, 32'h8000_0001, 3'd1, 1, 5'd1, 8'd4, 1'b0);
    run("R4", 0, 8'h0, 4'd0, 32'h8000_0001, 3'd1, 0, 5'd1, 8'd32, 1'b0);
    run("R4", 0, 8'h0, 4'd0, 32'h1234_5678, 3'd0, 1, 5'd7, 8'd0, 1'b1);
    // R5 zero count
    run("R5", 0, 8'h0, 4'd0, 32'hCAFE_F00D, 3'd3, 0, 5'd0, 8'd0, 1'b1);
    run("R5", 0, 8'h0, 4'd0, 32'hCAFE_F00D, 3'd2, 1, 5'd9, 8'd0, 1'b0);
    // R6 left shifts, both codes
    run("R6", 0, 8'h0, 4'd0, 32'h4000_0001, 3'd0, 0, 5'd1, 8'd0, 1'b0);
    run("R6", 0, 8'h0, 4'd0, 32'h4000_0001, 3'd5, 0, 5'd2, 8'd0, 1'b0);
    run("R6", 0, 8'h0, 4'd0, 32'h0000_0003, 3'd5, 0, 5'd31, 8'd0, 1'b0);
    // R7, R8
    run("R7", 0, 8'h0, 4'd0, 32'hF000_0010, 3'd1, 0, 5'd5, 8'd0, 1'b0);
    run("R8", 0, 8'h0, 4'd0, 32'h8000_0040, 3'd2, 0, 5'd7, 8'd0, 1'b0);
    run("R8", 0, 8'h0, 4'd0, 32'h7000_0000, 3'd2, 0, 5'd31, 8'd0, 1'b1);
    // R9 logical at and beyond 32
    run("R9", 0, 8'h0, 4'd0, 32'h0000_0001, 3'd0, 1, 5'd0, 8'd32, 1'b0);
    run("R9", 0, 8'h0, 4'd0, 32'h8000_0000, 3'd1, 1, 5'd0, 8'd32, 1'b0);
    run("R9", 0, 8'h0, 4'd0, 32'hFFFF_FFFF, 3'd5, 1, 5'd0, 8'd33, 1'b1);
    run("R9", 0, 8'h0, 4'd0, 32'hFFFF_FFFF, 3'd1, 1, 5'd0, 8'd255, 1'b1);
    // R10 arithmetic saturation
    run("R10", 0, 8'h0, 4'd0, 32'h8000_0000, 3'd2, 1, 5'd0, 8'd32, 1'b0);
    run("R10", 0, 8'h0, 4'd0, 32'h7FFF_FFFF, 3'd2, 1, 5'd0, 8'd200, 1'b1);
    // R11 rotate right
    run("R11", 0, 8'h0, 4'd0, 32'h0000_0012, 3'd3, 0, 5'd4, 8'd0, 1'b0);
    run("R11", 0, 8'h0, 4'd0, 32'h0000_0012, 3'd3, 1, 5'd0, 8'd36, 1'b0);
    run("R11", 0, 8'h0, 4'd0, 32'h8000_0000, 3'd3, 1, 5'd0, 8'd64, 1'b0);
    run("R11", 0, 8'h0, 4'd0, 32'h0000_0001, 3'd3, 1, 5'd0, 8'd32, 1'b1);
    // R12 extended rotate ignores count
    run("R12", 0, 8'h0, 4'd0, 32'h0000_0003, 3'd4, 0, 5'd0, 8'd0, 1'b1);
    run("R12", 0, 8'h0, 4'd0, 32'hFFFF_FFFE, 3'd4, 1, 5'd9, 8'd77, 1'b0);
    // R13 spare codes
    run("R13", 0, 8'h0, 4'd0, 32'h1357_9BDF, 3'd6, 0, 5'd12, 8'd0, 1'b1);
    run("R13", 0, 8'h0, 4'd0, 32'h1357_9BDF, 3'd7, 1, 5'd0, 8'd40, 1'b0);

    // constrained random mix, biased toward boundary counts
    for (int t = 0; t < 3000; t++) begin
      logic s, fr, ci;
      logic [7:0] b, rc;
      logic [3:0] r;
      logic [31:0] v;
      logic [2:0] k;
      logic [4:0] ia;
      int pick;
      s  = ($urandom % 8) == 0;
      b  = 8'($urandom);
      r  = 4'($urandom);
      v  = $urandom;
      k  = 3'($urandom % 8);
      fr = 1'($urandom);
      ia = 5'($urandom);
      ci = 1'($urandom);
      pick = $urandom % 4;
      if (pick == 0) begin
        case ($urandom % 6)
          0: rc = 8'd0;
          1: rc = 8'd31;
          2: rc = 8'd32;
          3: rc = 8'd33;
          4: rc = 8'd64;
          default: rc = 8'd255;
        endcase
      end else begin
        rc = 8'($urandom);
      end
      run(tag_of(s, k, fr ? int'(rc) : int'(ia)), s, b, r, v, k, fr, ia, rc, ci);
    end

    // R1 again: reset mid-run
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1", op_out, carry_out, 32'h0, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule